// File: doc/BRIEF.md
# Shared-Table NPN Logic Element Pair

This block holds two 4-input logic elements that draw on a single 16-entry truth table. One element, the direct one, uses its four inputs as the table address unchanged. The other element, the transformed one, passes its inputs through a per-input inverter stage and a reordering stage before the lookup, and can invert the looked-up bit afterwards. The transformed element can therefore realise any function that is NPN-equivalent to the stored one: input negation, input permutation and output negation in any combination. A swap bit in the configuration chooses which of the two elements is the direct one.

Each element ends in a basic output stage. A D flip-flop captures the element's combinational value on every clock, and a per-element select bit picks either the combinational value or the flip-flop as the element's output. All configuration (table, transform, swap and output selects) sits in one 32-bit serial shift chain. The chain is loaded one bit per clock while the load enable is high and holds its contents while the enable is low. Its last stage is brought out so that chains can be cascaded.

Top module: `npn_lut_pair`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts `cfg_din` into the chain, and `cfg_dout` shows the bit shifted in 32 edges earlier. With the 32-bit word W shifted in from W[31] down to W[0], the fields are as follows. Table entry i is W[31-i]. Negate bit for input j is W[15-j]. Address selector k occupies W[11-2k] (MSB) and W[10-2k] (LSB). Output negate is W[3], swap is W[2], the element A output select is W[1] and the element B output select is W[0].
- R2: While `cfg_en` is low the configuration does not change, whatever `cfg_din` does, so outputs and `cfg_dout` keep their behaviour.
- R3: The direct element's combinational value is table[v], where v is its 4-bit input with input bit i as address bit i.
- R4: In the transformed element, input j is inverted before the lookup when its negate bit is 1.
- R5: In the transformed element, address bit k is taken from (negated) input number sel[k]. A selector set that is not a permutation is legal and repeats inputs as selected.
- R6: The output negate bit inverts only the transformed element's value, never the direct element's.
- R7: Swap = 1 makes A direct and B transformed; swap = 0 makes B direct and A transformed.
- R8: With an element's output select at 1, its output is the combinational value captured at the previous rising edge. With the select at 0 it follows the combinational value with no clock delay.
- R9: Synchronous active-high `rst` clears the configuration chain and both output flip-flops to 0, so after reset every output reads 0 and `cfg_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Last stage of the configuration chain |
| a_in | input | 4 | Element A inputs |
| b_in | input | 4 | Element B inputs |
| a_out | output | 1 | Element A output |
| b_out | output | 1 | Element B output |

## Verification
Combinational outputs change in the same cycle as the inputs. A registered output shows a value one rising edge after the inputs that produced it. Each chain shift appears on `cfg_dout` right after the edge that performs it. The driver changes inputs on the falling edge and queues the expected values. The monitor compares them 1 ns after the next rising edge, when both the combinational and the registered forms are due and the inputs are still held. For the latency case, the bench also samples just after a falling-edge input change to show that a registered output still holds the previous value while a combinational one has already moved. Chain output is compared before every shift against the previously loaded word.

// File: rtl/npn_pkg.sv
package npn_pkg;

    localparam int N_IN      = 4;
    localparam int N_ELEM    = 2;
    localparam int TBL_DEPTH = 1 << N_IN;
    localparam int SEL_W     = $clog2(N_IN);
    localparam int CFG_W     = TBL_DEPTH + N_IN + N_IN * SEL_W + 1 + 1 + N_ELEM;

    typedef logic [N_IN-1:0]             addr_t;
    typedef logic [N_IN-1:0][SEL_W-1:0]  sel_vec_t;

    typedef struct packed {
        logic [TBL_DEPTH-1:0] tt_bits;
        logic [N_IN-1:0]      neg;
        sel_vec_t             sel;
        logic                 oneg;
        logic                 swap;
        logic [N_ELEM-1:0]    regsel;
    } cfg_t;

    // First bit shifted in ends at the MSB of the chain; fields follow in
    // shift order, selectors MSB first.
    function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] sr);
        cfg_t c;
        int   p;
        p = CFG_W - 1;
        for (int i = 0; i < TBL_DEPTH; i++) begin
            c.tt_bits[i] = sr[p];
            p--;
        end
        for (int j = 0; j < N_IN; j++) begin
            c.neg[j] = sr[p];
            p--;
        end
        for (int k = 0; k < N_IN; k++) begin
            for (int b = SEL_W - 1; b >= 0; b--) begin
                c.sel[k][b] = sr[p];
                p--;
            end
        end
        c.oneg = sr[p];
        p--;
        c.swap = sr[p];
        p--;
        for (int e = 0; e < N_ELEM; e++) begin
            c.regsel[e] = sr[p];
            p--;
        end
        return c;
    endfunction

endpackage

// File: rtl/npn_cfg_chain.sv
module npn_cfg_chain #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] sr,
    output logic         dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (en) begin
            sr <= {sr[W-2:0], din};
        end
    end

    assign dout = sr[W-1];

endmodule

// File: rtl/npn_xform.sv
module npn_xform
    import npn_pkg::*;
(
    input  addr_t    in_vec,
    input  addr_t    neg_mask,
    input  sel_vec_t sel,
    output addr_t    addr
);

    addr_t flipped;

    assign flipped = in_vec ^ neg_mask;

    for (genvar k = 0; k < N_IN; k++) begin : g_route
        assign addr[k] = flipped[sel[k]];
    end

endmodule

// File: rtl/npn_table_read.sv
module npn_table_read
    import npn_pkg::*;
(
    input  logic [TBL_DEPTH-1:0]        tt,
    input  logic [N_ELEM-1:0][N_IN-1:0] addr,
    input  logic [N_ELEM-1:0]           inv,
    output logic [N_ELEM-1:0]           dout
);

    for (genvar e = 0; e < N_ELEM; e++) begin : g_port
        assign dout[e] = tt[addr[e]] ^ inv[e];
    end

endmodule

// File: rtl/npn_out_stage.sv
module npn_out_stage
    import npn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_ELEM-1:0] comb,
    input  logic [N_ELEM-1:0] regsel,
    output logic [N_ELEM-1:0] q,
    output logic [N_ELEM-1:0] dout
);

    for (genvar e = 0; e < N_ELEM; e++) begin : g_ble
        always_ff @(posedge clk) begin
            if (rst) begin
                q[e] <= 1'b0;
            end else begin
                q[e] <= comb[e];
            end
        end
        assign dout[e] = regsel[e] ? q[e] : comb[e];
    end

endmodule

// File: rtl/npn_lut_pair.sv
module npn_lut_pair
    import npn_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic            cfg_din,
    output logic            cfg_dout,
    input  logic [N_IN-1:0] a_in,
    input  logic [N_IN-1:0] b_in,
    output logic            a_out,
    output logic            b_out
);

    logic [CFG_W-1:0]           cfg_sr;
    cfg_t                       cfg;
    addr_t                      x_src;
    addr_t                      x_addr;
    logic [N_ELEM-1:0][N_IN-1:0] rd_addr;
    logic [N_ELEM-1:0]          inv_mask;
    logic [N_ELEM-1:0]          elem_comb;
    logic [N_ELEM-1:0]          elem_q;
    logic [N_ELEM-1:0]          elem_out;

    npn_cfg_chain #(.W(CFG_W)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg_en),
        .din  (cfg_din),
        .sr   (cfg_sr),
        .dout (cfg_dout)
    );

    assign cfg = unpack_cfg(cfg_sr);

    // Only one transform stage: it serves whichever element is not direct.
    assign x_src = cfg.swap ? b_in : a_in;

    npn_xform u_xform (
        .in_vec   (x_src),
        .neg_mask (cfg.neg),
        .sel      (cfg.sel),
        .addr     (x_addr)
    );

    always_comb begin
        if (cfg.swap) begin
            rd_addr[0] = a_in;
            rd_addr[1] = x_addr;
            inv_mask   = {cfg.oneg, 1'b0};
        end else begin
            rd_addr[0] = x_addr;
            rd_addr[1] = b_in;
            inv_mask   = {1'b0, cfg.oneg};
        end
    end

    npn_table_read u_read (
        .tt   (cfg.tt_bits),
        .addr (rd_addr),
        .inv  (inv_mask),
        .dout (elem_comb)
    );

    npn_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .comb   (elem_comb),
        .regsel (cfg.regsel),
        .q      (elem_q),
        .dout   (elem_out)
    );

    assign a_out = elem_out[0];
    assign b_out = elem_out[1];

endmodule

// File: rtl/npn_lut_pair_chk.sv
module npn_lut_pair_chk
    import npn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_en,
    input logic              cfg_din,
    input logic [CFG_W-1:0]  cfg_sr,
    input cfg_t              cfg,
    input logic [N_IN-1:0]   a_in,
    input logic [N_IN-1:0]   b_in,
    input logic [N_ELEM-1:0] elem_comb,
    input logic [N_ELEM-1:0] elem_q,
    input logic              a_out,
    input logic              b_out
);

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_sr[0] == $past(cfg_din));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_sr));

    // R7
    a_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.swap && !cfg.regsel[0]) |-> a_out == cfg.tt_bits[a_in]);

    // R7
    b_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.swap && !cfg.regsel[1]) |-> b_out == cfg.tt_bits[b_in]);

    // R8
    a_reg_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && cfg.regsel[0]) |=> a_out == $past(elem_comb[0]));

    // R8
    b_reg_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && cfg.regsel[1]) |=> b_out == $past(elem_comb[1]));

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (elem_q == '0 && cfg_sr == '0));

endmodule

bind npn_lut_pair npn_lut_pair_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .cfg_din   (cfg_din),
    .cfg_sr    (cfg_sr),
    .cfg       (cfg),
    .a_in      (a_in),
    .b_in      (b_in),
    .elem_comb (elem_comb),
    .elem_q    (elem_q),
    .a_out     (a_out),
    .b_out     (b_out)
);

// File: tb/npn_lut_pair_tb_top.sv
`timescale 1ns/1ps
module npn_lut_pair_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_dout;
    logic [3:0] a_in = 4'd0;
    logic [3:0] b_in = 4'd0;
    logic       a_out;
    logic       b_out;

    always #2 clk = ~clk;

    npn_lut_pair dut_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_dout (cfg_dout),
        .a_in     (a_in),
        .b_in     (b_in),
        .a_out    (a_out),
        .b_out    (b_out)
    );

    typedef struct {
        bit    ea;
        bit    eb;
        string req;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    finished = 0;

    bit [31:0] prev_w = '0;
    bit [15:0] c_tt = '0;
    bit [3:0]  c_neg = '0;
    bit [7:0]  c_sel = '0;
    bit        c_oneg = 0;
    bit        c_swap = 0;
    bit        c_ra = 0;
    bit        c_rb = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit [31:0] pack_cfg(bit [15:0] tt, bit [3:0] neg, bit [7:0] sel,
                                           bit oneg, bit swap, bit ra, bit rb);
        bit [31:0] w = '0;
        for (int i = 0; i < 16; i++) w[31-i] = tt[i];
        for (int j = 0; j < 4; j++) w[15-j] = neg[j];
        for (int k = 0; k < 4; k++) begin
            w[11-2*k] = sel[2*k+1];
            w[10-2*k] = sel[2*k];
        end
        w[3] = oneg;
        w[2] = swap;
        w[1] = ra;
        w[0] = rb;
        return w;
    endfunction

    function automatic bit model(bit xf, bit [3:0] v);
        bit [3:0] x;
        bit [3:0] idx;
        if (!xf) return c_tt[v];
        x = v ^ c_neg;
        for (int k = 0; k < 4; k++) idx[k] = x[c_sel[2*k +: 2]];
        return c_tt[idx] ^ c_oneg;
    endfunction

    task automatic load(bit [15:0] tt, bit [3:0] neg, bit [7:0] sel,
                        bit oneg, bit swap, bit ra, bit rb);
        bit [31:0] w;
        w = pack_cfg(tt, neg, sel, oneg, swap, ra, rb);
        for (int i = 31; i >= 0; i--) begin
            @(negedge clk);
            check(cfg_dout == prev_w[i], "R1 chain out", cfg_dout, prev_w[i]);
            cfg_en  = 1'b1;
            cfg_din = w[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        check(cfg_dout == w[31], "R1 chain out", cfg_dout, w[31]);
        prev_w = w;
        c_tt = tt; c_neg = neg; c_sel = sel; c_oneg = oneg;
        c_swap = swap; c_ra = ra; c_rb = rb;
    endtask

    task automatic drive(input bit [3:0] a, input bit [3:0] b, input string req);
        item_t it;
        @(negedge clk);
        a_in = a;
        b_in = b;
        it.ea  = model(!c_swap, a);
        it.eb  = model(c_swap, b);
        it.req = req;
        q.push_back(it);
    endtask

    task automatic run_all(input string req);
        for (int v = 0; v < 16; v++) drive(v[3:0], 4'(15 - v), req);
        repeat (2) @(posedge clk);
    endtask

    // Monitor: items queued at a falling edge are due 1 ns after the next rising edge.
    always @(posedge clk) begin
        item_t it;
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            check(a_out == it.ea, {it.req, " A"}, a_out, it.ea);
            check(b_out == it.eb, {it.req, " B"}, b_out, it.eb);
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit e_old;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: reset state, zero table drives every output to 0
        check(cfg_dout == 1'b0, "R9 chain out", cfg_dout, 0);
        run_all("R9");

        // R3: identity transform, both elements read the table directly
        load(16'h1F6B, 4'h0, 8'hE4, 0, 1, 0, 0);
        run_all("R3");

        // R4: input negation only
        load(16'h1F6B, 4'b0101, 8'hE4, 0, 1, 0, 0);
        run_all("R4");
        load(16'hC3A7, 4'b1010, 8'hE4, 0, 0, 0, 0);
        run_all("R4");

        // R5: true permutation and non-permutation selector sets
        load(16'h1F6B, 4'h0, 8'h39, 0, 1, 0, 0);
        run_all("R5 rotate");
        load(16'h96E1, 4'h0, 8'h00, 0, 0, 0, 0);
        run_all("R5 repeat");
        load(16'h96E1, 4'h3, 8'h55, 0, 1, 0, 0);
        run_all("R5 repeat");

        // R6 and R7: output negation on the transformed side only, both swap values
        load(16'h2B4D, 4'h0, 8'hE4, 1, 1, 0, 0);
        run_all("R6 swap1");
        load(16'h2B4D, 4'h0, 8'hE4, 1, 0, 0, 0);
        run_all("R7 swap0");

        // R8: registered outputs
        load(16'h6A5C, 4'b0011, 8'h1B, 1, 1, 1, 1);
        run_all("R8 both reg");

        // R8: latency, A registered, B combinational
        load(16'h6A5C, 4'b0011, 8'h1B, 1, 0, 1, 0);
        drive(4'd3, 4'd3, "R8 latency");
        @(posedge clk);
        #1;
        e_old = model(!c_swap, 4'd3);
        @(negedge clk);
        a_in = 4'd12;
        b_in = 4'd12;
        #1;
        check(a_out == e_old, "R8 held", a_out, e_old);
        check(b_out == model(c_swap, 4'd12), "R8 comb now", b_out, model(c_swap, 4'd12));
        @(posedge clk);
        #1;
        check(a_out == model(!c_swap, 4'd12), "R8 after edge", a_out, model(!c_swap, 4'd12));

        // R2: chain holds while cfg_en is low
        load(16'hD2B9, 4'b1001, 8'h4E, 1, 1, 0, 1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cfg_din = ~cfg_din;
        end
        check(cfg_dout == prev_w[31], "R2 chain out", cfg_dout, prev_w[31]);
        run_all("R2");

        // Random configurations over the whole transform space
        for (int n = 0; n < 12; n++) begin
            bit [31:0] r;
            r = $urandom;
            load(r[31:16], r[15:12], r[11:4], r[3], r[2], r[1], r[0]);
            run_all("random R4/R5/R6/R7");
        end

        // R9: reset mid-run clears configuration and flip-flops
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        prev_w = '0;
        c_tt = '0; c_neg = '0; c_sel = '0; c_oneg = 0;
        c_swap = 0; c_ra = 0; c_rb = 0;
        check(cfg_dout == 1'b0, "R9 chain out", cfg_dout, 0);
        check(a_out == 1'b0 && b_out == 1'b0, "R9 outputs", {a_out, b_out}, 0);
        run_all("R9 after");

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule